// File: doc/BRIEF.md
# Priority-Group Least-Recently-Granted Arbiter

This block picks one winner per cycle among a set of requesters competing for one slave-side port. It holds two independent arbiter channels, one for read addresses and one for write addresses. Each requester owns exactly one slot in an ordered list and carries a programmable priority value. Requesters with equal priority form a group. The grant goes to the highest-valued group that has an eligible request, and within that group to the member nearest the top of the list. The winner then moves below every other member of its group. Giving every requester its own value yields a fixed-priority encoder. Giving all the same value yields pure least-recently-granted rotation. Any mix of the two is also possible.

The grant is registered, so the decision formed from this cycle's requests drives the grant output in the next cycle. A QoS restriction input limits the competition to a permit mask. While that restriction is active, no default grant is issued. Priorities are reprogrammed and read back through a 32-bit write word whose layout names the slot, the requester and the priority. A change is accepted only when the named slot really holds the named requester.

Top module: `pglrg_arbiter`

## Requirements
- R1: After reset the grant outputs are zero, slot s holds requester s, and each requester's priority equals its entry in the reset-priority parameter.
- R2: A grant output has at most one bit set. It changes only on the rising edge that follows the requests it answers.
- R3: A larger priority value wins. The grant goes to an eligible requester of the highest priority value present among the eligible requests.
- R4: Within a group, the eligible member in the lowest-numbered slot wins and then moves to the last slot. The slots it passes each move up by one. With all priorities equal, a full request set is served in strict rotation.
- R5: With all priorities distinct, the same eligible request set always grants the same requester.
- R6: With no eligible request and QoS restriction off, the grant goes to the requester with the highest priority in the lowest slot, and the slot order does not change.
- R7: With QoS restriction on, only requesters whose permit bit is 1 can be granted. If none of them requests, the grant is all zero.
- R8: A programming word has the requester number in bits [7:0], the new priority in bits [15:8] and the slot number in bits [31:24]. It takes effect only if that slot currently holds that requester. Otherwise it is ignored.
- R9: A requester whose priority is reprogrammed moves to the last slot, and so to the bottom of its new group.
- R10: A write whose bits [31:8] equal 0xFF0000 selects the slot in bits [7:0] for readback. The read data then shows the slot number in [31:24], zero in [23:16], the priority in [15:8] and the requester in [7:0].
- R11: Register offset 0x08 addresses the read-address channel and offset 0x0C addresses the write-address channel. A write to one channel leaves the other's state untouched, and the read data follows the offset.
- R12: In a cycle that carries a register write to a channel, that channel holds its grant and makes no arbitration decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | N_REQ | Read-address channel requests, one per requester |
| wr_req_i | input | N_REQ | Write-address channel requests, one per requester |
| permit_i | input | N_REQ | QoS permit mask, shared by both channels |
| qos_active_i | input | 1 | QoS restriction in force |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register offset within the port's 0x20-byte space |
| reg_wdata_i | input | 32 | Register write word |
| reg_rdata_o | output | 32 | Readback word of the channel at reg_addr_i |
| rd_grant_o | output | N_REQ | Registered one-hot grant, read-address channel |
| wr_grant_o | output | N_REQ | Registered one-hot grant, write-address channel |

## Verification
Each grant is due one rising edge after the requests it answers. The bench drives every input at a falling edge and compares both grant outputs at the next falling edge, after exactly one rising edge. A readback select takes one write cycle, and the read data is sampled at the falling edge after it with the offset held. The bench keeps a requirement-level model of each channel's slot list and priorities and advances it once per rising edge. A write cycle leaves the addressed channel's model unchanged, so held grants are checked in the same cycle as the write (R12).

// File: rtl/pglrg_pkg.sv
package pglrg_pkg;
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned OFS_W      = 5;
  localparam int unsigned N_CH       = 2;
  localparam logic [OFS_W-1:0] OFS_RD_CH = 5'h08;
  localparam logic [OFS_W-1:0] OFS_WR_CH = 5'h0C;
  localparam logic [23:0] SEL_KEY    = 24'hFF0000;

  typedef struct packed {
    logic [FIELD_W-1:0] slot;
    logic [FIELD_W-1:0] mid;
    logic [FIELD_W-1:0] prio;
    logic [FIELD_W-1:0] req;
  } prog_word_t;
endpackage

// File: rtl/pglrg_pick.sv
module pglrg_pick #(
  parameter int unsigned N_REQ = 4,
  parameter int unsigned IDX_W = 2,
  parameter int unsigned PRIO_W = 8
) (
  input  logic [N_REQ-1:0][IDX_W-1:0]  slot_i,
  input  logic [N_REQ-1:0][PRIO_W-1:0] prio_i,
  input  logic [N_REQ-1:0]             mask_i,
  output logic                         found_o,
  output logic [IDX_W-1:0]             slot_o,
  output logic [IDX_W-1:0]             req_o
);
  // strict compare keeps the upper slot on ties
  always_comb begin
    logic [IDX_W-1:0]  r;
    logic [PRIO_W-1:0] best_p;
    found_o = 1'b0;
    slot_o  = '0;
    req_o   = '0;
    best_p  = '0;
    for (int s = 0; s < int'(N_REQ); s++) begin
      r = slot_i[s];
      if (mask_i[r] && (!found_o || prio_i[r] > best_p)) begin
        found_o = 1'b1;
        best_p  = prio_i[r];
        slot_o  = IDX_W'(s);
        req_o   = r;
      end
    end
  end
endmodule

// File: rtl/pglrg_channel.sv
module pglrg_channel
  import pglrg_pkg::*;
#(
  parameter int unsigned N_REQ = 4,
  parameter logic [N_REQ*FIELD_W-1:0] RST_PRIO = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_REQ-1:0]  req_i,
  input  logic [N_REQ-1:0]  permit_i,
  input  logic              qos_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [N_REQ-1:0]  grant_o
);
  localparam int unsigned IDX_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1;
  localparam int unsigned PRIO_W = FIELD_W;

  typedef logic [N_REQ-1:0][IDX_W-1:0]  slot_vec_t;
  typedef logic [N_REQ-1:0][PRIO_W-1:0] prio_vec_t;

  slot_vec_t            slot_q;
  prio_vec_t            prio_q;
  logic [N_REQ-1:0]     grant_q;
  logic [FIELD_W-1:0]   rd_sel_q;

  function automatic slot_vec_t to_bottom(slot_vec_t l, logic [IDX_W-1:0] k);
    slot_vec_t o;
    for (int s = 0; s < int'(N_REQ); s++) begin
      if (s < int'(k))                o[s] = l[s];
      else if (s < int'(N_REQ) - 1)   o[s] = l[(s+1) % int'(N_REQ)];
      else                            o[s] = l[k];
    end
    return o;
  endfunction

  // write decode
  prog_word_t pw;
  logic       is_sel, prog_ok;
  assign pw     = prog_word_t'(wdata_i);
  assign is_sel = (wdata_i[WORD_W-1:FIELD_W] == SEL_KEY);

  always_comb begin
    prog_ok = 1'b0;
    for (int s = 0; s < int'(N_REQ); s++)
      if (pw.slot == FIELD_W'(s) && pw.req < FIELD_W'(N_REQ) &&
          slot_q[s] == pw.req[IDX_W-1:0])
        prog_ok = 1'b1;
    prog_ok = prog_ok && wr_i && !is_sel;
  end

  // arbitration
  logic [N_REQ-1:0] elig;
  logic             act_found, dflt_found;
  logic [IDX_W-1:0] act_slot, act_req, dflt_slot, dflt_req;

  assign elig = req_i & (qos_i ? permit_i : {N_REQ{1'b1}});

  pglrg_pick #(.N_REQ(N_REQ), .IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_pick_act (
    .slot_i(slot_q), .prio_i(prio_q), .mask_i(elig),
    .found_o(act_found), .slot_o(act_slot), .req_o(act_req)
  );

  pglrg_pick #(.N_REQ(N_REQ), .IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_pick_dflt (
    .slot_i(slot_q), .prio_i(prio_q), .mask_i({N_REQ{1'b1}}),
    .found_o(dflt_found), .slot_o(dflt_slot), .req_o(dflt_req)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(N_REQ); s++) begin
        slot_q[s] <= IDX_W'(s);
        prio_q[s] <= RST_PRIO[s*FIELD_W +: FIELD_W];
      end
      grant_q  <= '0;
      rd_sel_q <= '0;
    end else if (wr_i) begin
      if (is_sel) begin
        rd_sel_q <= wdata_i[FIELD_W-1:0];
      end else if (prog_ok) begin
        prio_q[pw.req[IDX_W-1:0]] <= pw.prio;
        slot_q <= to_bottom(slot_q, pw.slot[IDX_W-1:0]);
      end
    end else if (act_found) begin
      grant_q <= N_REQ'(1) << act_req;
      slot_q  <= to_bottom(slot_q, act_slot);
    end else if (!qos_i && dflt_found) begin
      grant_q <= N_REQ'(1) << dflt_req;
    end else begin
      grant_q <= '0;
    end
  end

  assign grant_o = grant_q;

  // readback
  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < int'(N_REQ); s++)
      if (rd_sel_q == FIELD_W'(s))
        rdata_o = {rd_sel_q, FIELD_W'(0), prio_q[slot_q[s]], FIELD_W'(slot_q[s])};
  end

  // slot ownership map
  logic [N_REQ-1:0] owned;
  always_comb begin
    owned = '0;
    for (int r = 0; r < int'(N_REQ); r++)
      for (int s = 0; s < int'(N_REQ); s++)
        if (slot_q[s] == IDX_W'(r)) owned[r] = 1'b1;
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_q));

  // R12
  hold_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> $stable(grant_q));

  // R7
  qos_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && qos_i) |=> ((grant_q & ~$past(permit_i)) == '0));

  // R6
  idle_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !act_found) |=> $stable(slot_q));

  // R8
  one_slot_each_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owned == {N_REQ{1'b1}});
endmodule

// File: rtl/pglrg_arbiter.sv
module pglrg_arbiter
  import pglrg_pkg::*;
#(
  parameter int unsigned N_REQ = 4,
  parameter logic [N_REQ*FIELD_W-1:0] RST_PRIO = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_REQ-1:0]  rd_req_i,
  input  logic [N_REQ-1:0]  wr_req_i,
  input  logic [N_REQ-1:0]  permit_i,
  input  logic              qos_active_i,
  input  logic              reg_wr_i,
  input  logic [OFS_W-1:0]  reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic [N_REQ-1:0]  rd_grant_o,
  output logic [N_REQ-1:0]  wr_grant_o
);
  localparam logic [N_CH-1:0][OFS_W-1:0] CH_OFS = {OFS_WR_CH, OFS_RD_CH};

  logic [N_CH-1:0][N_REQ-1:0]  ch_req, ch_grant;
  logic [N_CH-1:0][WORD_W-1:0] ch_rdata;
  logic [N_CH-1:0]             ch_wr;

  assign ch_req[0]  = rd_req_i;
  assign ch_req[1]  = wr_req_i;
  assign rd_grant_o = ch_grant[0];
  assign wr_grant_o = ch_grant[1];

  for (genvar c = 0; c < int'(N_CH); c++) begin : g_ch
    assign ch_wr[c] = reg_wr_i && (reg_addr_i == CH_OFS[c]);

    pglrg_channel #(.N_REQ(N_REQ), .RST_PRIO(RST_PRIO)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (ch_req[c]),
      .permit_i (permit_i),
      .qos_i    (qos_active_i),
      .wr_i     (ch_wr[c]),
      .wdata_i  (reg_wdata_i),
      .rdata_o  (ch_rdata[c]),
      .grant_o  (ch_grant[c])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int c = 0; c < int'(N_CH); c++)
      if (reg_addr_i == CH_OFS[c]) reg_rdata_o = ch_rdata[c];
  end

  // R11
  single_write_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_wr));
endmodule

// File: tb/pglrg_arbiter_test.sv
`timescale 1ns/1ps
module pglrg_arbiter_test;
  localparam int N = 4;
  localparam logic [31:0] RP = {8'd1, 8'd5, 8'd1, 8'd1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_req = '0, wr_req = '0, permit = '0;
  logic        qos = 1'b0, reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [3:0]  rd_grant, wr_grant;

  always #10 clk = ~clk;

  pglrg_arbiter #(.N_REQ(N), .RST_PRIO(RP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(rd_req), .wr_req_i(wr_req),
    .permit_i(permit), .qos_active_i(qos), .reg_wr_i(reg_wr),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .rd_grant_o(rd_grant), .wr_grant_o(wr_grant)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int ml[2][N];
  int mp[2][N];
  int msel[2];
  logic [3:0] mg[2];

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic mmove(int ch, int k);
    int t = ml[ch][k];
    for (int s = k; s < N-1; s++) ml[ch][s] = ml[ch][s+1];
    ml[ch][N-1] = t;
  endtask

  function automatic int mslot(int ch, int r);
    for (int s = 0; s < N; s++) if (ml[ch][s] == r) return s;
    return -1;
  endfunction

  task automatic mstep(int ch, logic [3:0] rq, logic [3:0] pm, bit q);
    int best = -1, bp = -1;
    for (int s = 0; s < N; s++) begin
      int r = ml[ch][s];
      if (rq[r] && (!q || pm[r]) && mp[ch][r] > bp) begin bp = mp[ch][r]; best = s; end
    end
    if (best >= 0) begin
      mg[ch] = 4'(1 << ml[ch][best]);
      mmove(ch, best);
    end else if (!q) begin
      for (int s = 0; s < N; s++)
        if (mp[ch][ml[ch][s]] > bp) begin bp = mp[ch][ml[ch][s]]; best = s; end
      mg[ch] = 4'(1 << ml[ch][best]);
    end else mg[ch] = '0;
  endtask

  task automatic mwrite(int ch, logic [31:0] d);
    if (d[31:8] == 24'hFF0000) msel[ch] = int'(d[7:0]);
    else if (d[31:24] < N && d[7:0] < N && ml[ch][d[31:24]] == int'(d[7:0])) begin
      mp[ch][d[7:0]] = int'(d[15:8]);
      mmove(ch, int'(d[31:24]));
    end
  endtask

  // one rising edge; grants of both channels checked at the next falling edge
  task automatic cyc(logic [3:0] rr, logic [3:0] wq, logic [3:0] pm, bit q,
                     bit w, logic [4:0] a, logic [31:0] d, string tag);
    rd_req = rr; wr_req = wq; permit = pm; qos = q;
    reg_wr = w; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      bit hit = w && (a == (c == 0 ? 5'h08 : 5'h0C));
      if (hit) mwrite(c, d); else mstep(c, c == 0 ? rr : wq, pm, q);
    end
    @(negedge clk);
    reg_wr = 1'b0;
    chk({28'd0, rd_grant}, {28'd0, mg[0]}, {tag, " rd grant"});
    chk({28'd0, wr_grant}, {28'd0, mg[1]}, {tag, " wr grant"});
  endtask

  task automatic readback(int ch, int s, string tag);
    logic [4:0] a = ch == 0 ? 5'h08 : 5'h0C;
    int r;
    cyc('0, '0, '0, 0, 1, a, {24'hFF0000, 8'(s)}, "R12 sel");
    reg_addr = a;
    #1;
    r = ml[ch][s];
    chk(reg_rdata, {8'(s), 8'h00, 8'(mp[ch][r]), 8'(r)}, tag);
  endtask

  task automatic prog(int ch, int r, int p, string tag);
    int s = mslot(ch, r);
    cyc('0, '0, '0, 0, 1, ch == 0 ? 5'h08 : 5'h0C, {8'(s), 8'h00, 8'(p), 8'(r)}, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      msel[c] = 0; mg[c] = '0;
      for (int s = 0; s < N; s++) begin ml[c][s] = s; mp[c][s] = int'(RP[s*8 +: 8]); end
    end
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk({28'd0, rd_grant}, 32'd0, "R1 rd grant in reset");
    chk({28'd0, wr_grant}, 32'd0, "R1 wr grant in reset");
    rst_n = 1'b1;
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < N; s++) readback(c, s, "R1 R10 reset readback");

    // R6 default grant to requester 2 (priority 5), order unchanged
    cyc('0, '0, '0, 0, 0, 5'h0, '0, "R6 idle default");
    chk({28'd0, rd_grant}, 32'h4, "R6 default is highest priority");
    // R3 highest group wins repeatedly
    cyc(4'hF, 4'hF, '0, 0, 0, 5'h0, '0, "R3 all request");
    chk({28'd0, rd_grant}, 32'h4, "R3 group 5 wins");
    // R4 rotation inside group 1: 0,1,3
    for (int i = 0; i < 3; i++) cyc(4'hB, 4'hB, '0, 0, 0, 5'h0, '0, "R4 group rotation");
    chk({28'd0, rd_grant}, 32'h8, "R4 third member served last");

    // R2 mixed request sweep, channels fed differently
    for (int i = 0; i < 64; i++)
      cyc(4'((i * 7 + 3) & 15), 4'(i & 15), '0, 0, 0, 5'h0, '0, "R2 sweep");

    // R7 QoS sweep over all permit and request patterns
    for (int p = 0; p < 16; p++)
      for (int r = 0; r < 16; r++)
        cyc(4'(r), 4'(15 - r), 4'(p), 1, 0, 5'h0, '0, "R7 qos");

    // R8 valid program and a mismatched write on the read channel
    prog(0, 1, 9, "R8 valid write");
    cyc('0, '0, '0, 0, 1, 5'h08, {8'((mslot(0, 3) + 1) % N), 8'h00, 8'd20, 8'd3}, "R8 mismatched write");
    for (int s = 0; s < N; s++) readback(0, s, "R8 R9 readback");
    chk(32'(ml[0][N-1]), 32'd1, "R9 model sanity");
    // R9 requester 0 joins group 9 below requester 1
    prog(0, 0, 9, "R9 join group");
    cyc(4'h3, '0, '0, 0, 0, 5'h0, '0, "R9 first in new group");
    chk({28'd0, rd_grant}, 32'h2, "R9 earlier member first");
    cyc(4'h3, '0, '0, 0, 0, 5'h0, '0, "R9 second in new group");
    chk({28'd0, rd_grant}, 32'h1, "R9 joined member second");

    // R12 write to read channel with requests: rd held, wr arbitrates (R11)
    cyc(4'hF, 4'hF, '0, 0, 1, 5'h08, {24'hFF0000, 8'd0}, "R12 R11 write stalls one channel");

    // R5 distinct priorities on the write channel
    prog(1, 0, 40, "R5 prog"); prog(1, 1, 30, "R5 prog");
    prog(1, 2, 20, "R5 prog"); prog(1, 3, 10, "R5 prog");
    for (int k = 0; k < 2; k++)
      for (int r = 1; r < 16; r++) begin
        cyc('0, 4'(r), '0, 0, 0, 5'h0, '0, "R5 fixed");
        chk({28'd0, wr_grant}, 32'(r & -r), "R5 lowest index wins");
      end
    for (int s = 0; s < N; s++) readback(0, s, "R11 rd channel untouched");
    for (int s = 0; s < N; s++) readback(1, s, "R11 wr channel readback");

    // R4 pure least-recently-granted on the read channel
    for (int r = 0; r < N; r++) prog(0, r, 7, "R4 prog");
    begin
      logic [3:0] seen = '0;
      for (int i = 0; i < N; i++) begin
        cyc(4'hF, '0, '0, 0, 0, 5'h0, '0, "R4 lru");
        seen |= rd_grant;
      end
      chk({28'd0, seen}, 32'hF, "R4 each served once in four grants");
    end
    cyc(4'hF, '0, '0, 0, 0, 5'h0, '0, "R4 wrap");
    // unknown offset ignored
    cyc('0, '0, '0, 0, 1, 5'h10, {8'd0, 8'd0, 8'd99, 8'd0}, "R11 other offset");
    for (int s = 0; s < N; s++) readback(0, s, "R11 other offset ignored");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule